// File: doc/BRIEF.md
# Four-Issue Wakeup/Select Instruction Window with Bypass Marking

This block is the scheduling window of a four-issue out-of-order core. It takes one renamed instruction per cycle through a valid/ready dispatch port. Each instruction carries two source tags, a destination tag and an opcode. Every cycle it selects up to four instructions whose operands are both available, oldest first. In the same cycle it broadcasts their destination tags back into the window, so that dependents can be picked on the following cycle.

When a source is woken by a producer, the window marks that operand as forwardable. The mark lasts only for the cycle right after the wakeup, so the read-port arbiter downstream can skip a register file read for it. Selection does not consider bank conflicts. The arbiter reports conflicts two cycles after issue with a per-slot kill mask. The window then recovers without stalling dispatch: it kills the conflicting instructions and the whole group that followed them, and takes back the readiness those killed producers had granted. An entry is released only after its two-cycle exposure to kills has passed.

Back-pressure rules: a dispatch transfer happens on a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` is high whenever at least one entry is free and does not depend on `disp_valid`. The issue slots have no ready signal, because the arbiter always takes the issued group.

Top module: `iq_window`

## Requirements
- R1: A dispatch is written into the window only when `disp_valid` and `disp_ready` are both high. `disp_ready` is high exactly when a free entry exists. A dispatch offered while `disp_ready` is low is dropped and never issues.
- R2: Each cycle, every valid, unissued entry with both source ready bits set competes. Up to four of them issue, in order of dispatch with the oldest first, filling issue slots from slot 0 upward with no gaps.
- R3: In the cycle a slot issues, its destination tag sets the ready bit of every matching source in the window. This includes an instruction being dispatched in that same cycle. A dependent can therefore issue on the next cycle.
- R4: `iss_byp` bit 2k belongs to source 1 of slot k and bit 2k+1 to source 2. A bit is 1 only when that source was woken by an instruction issued in the cycle immediately before.
- R5: A source woken two or more cycles before its instruction issues reports a bypass bit of 0.
- R6: When `kill_mask` is nonzero in cycle C, bit k names slot k of the group issued in cycle C-2. Those instructions lose their issued state and issue again later. Unnamed slots of that group are released normally.
- R7: On a kill, every instruction of the group issued in cycle C-1 is killed as well and issues again.
- R8: On a kill, no instruction issues in cycle C. Any source whose tag equals the destination of a killed instruction has its ready bit cleared, so dependents wait for the reissued producer.
- R9: An issued instruction that is not killed frees its entry at the end of the second cycle after its issue cycle. From then on `disp_ready` reflects the freed entry.
- R10: After reset the window is empty, `disp_ready` is 1 and no slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | A free entry exists |
| disp_src1 | input | TAG_W | Source 1 tag |
| disp_src1_rdy | input | 1 | Source 1 already available |
| disp_src2 | input | TAG_W | Source 2 tag |
| disp_src2_rdy | input | 1 | Source 2 already available |
| disp_dst | input | TAG_W | Destination tag |
| disp_op | input | OP_W | Opcode |
| iss_valid | output | WIDTH | Issue slot valid, slot 0 in bit 0 |
| iss_op | output | WIDTH*OP_W | Opcode per slot |
| iss_src1 | output | WIDTH*TAG_W | Source 1 tag per slot |
| iss_src2 | output | WIDTH*TAG_W | Source 2 tag per slot |
| iss_dst | output | WIDTH*TAG_W | Destination tag per slot |
| iss_byp | output | 2*WIDTH | Forwardable flags, two per slot |
| kill_mask | input | WIDTH | Conflict slots of the group issued two cycles earlier |

## Verification
The first pattern is a serial chain, one producer after another. Here each consumer must issue exactly one cycle after its producer with its forwarding flag set. This separates a working same-cycle wakeup from a late or missing one. In the second pattern five consumers wait on a single tag. This shows whether selection takes exactly four in dispatch order and whether the fifth, picked a cycle late, has its stale flag cleared. The third pattern is a kill on a three-deep chain, which shows whether reissue follows producer order, or whether a consumer leaks out early on readiness from a killed producer. Last, the window is filled to capacity, to show that dropped offers never issue and that entries come back exactly two cycles after issue.

// File: rtl/iq_pkg.sv
package iq_pkg;
  parameter int unsigned IQ_ENTRIES = 16;
  parameter int unsigned IQ_WIDTH   = 4;
  parameter int unsigned IQ_TAG_W   = 6;
  parameter int unsigned IQ_OP_W    = 8;
  localparam int unsigned IQ_NSRC   = 2;
endpackage

// File: rtl/iq_age_select.sv
module iq_age_select #(
  parameter int unsigned N    = 16,
  parameter int unsigned W    = 4,
  parameter int unsigned IDXW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_en,
  input  logic [IDXW-1:0]        alloc_idx,
  input  logic [N-1:0]           req,
  output logic [N-1:0]           grant,
  output logic [W-1:0]           slot_vld,
  output logic [W-1:0][IDXW-1:0] slot_idx
);
  localparam int unsigned RANKW = $clog2(N + 1);

  // older_q[j][e] = 1 when entry j was dispatched before entry e
  logic [N-1:0][N-1:0]   older_q;
  logic [N-1:0][RANKW-1:0] rank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (alloc_en) begin
      for (int j = 0; j < N; j++) begin
        older_q[alloc_idx][j] <= 1'b0;
        older_q[j][alloc_idx] <= (j != int'(alloc_idx));
      end
    end
  end

  always_comb begin
    for (int e = 0; e < N; e++) begin
      rank[e] = '0;
      for (int j = 0; j < N; j++)
        if (j != e && req[j] && older_q[j][e]) rank[e] = rank[e] + 1'b1;
      grant[e] = req[e] && (rank[e] < RANKW'(W));
    end
  end

  always_comb begin
    for (int k = 0; k < W; k++) begin
      slot_vld[k] = 1'b0;
      slot_idx[k] = '0;
      for (int e = 0; e < N; e++)
        if (grant[e] && rank[e] == RANKW'(k)) begin
          slot_vld[k] = 1'b1;
          slot_idx[k] = IDXW'(e);
        end
    end
  end
endmodule

// File: rtl/iq_repair_track.sv
module iq_repair_track #(
  parameter int unsigned N    = 16,
  parameter int unsigned W    = 4,
  parameter int unsigned IDXW = 4,
  parameter int unsigned TAGW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             slot_vld,
  input  logic [W-1:0][IDXW-1:0]   slot_idx,
  input  logic [W-1:0][TAGW-1:0]   slot_dst,
  input  logic [W-1:0]             kill_mask,
  output logic [N-1:0]             kill_ent,
  output logic [N-1:0]             free_ent,
  output logic [2*W-1:0]           ktag_vld,
  output logic [2*W-1:0][TAGW-1:0] ktag
);
  // d1: group issued last cycle, d2: group issued two cycles ago
  logic [W-1:0]           d1_vld, d2_vld;
  logic [W-1:0][IDXW-1:0] d1_idx, d2_idx;
  logic [W-1:0][TAGW-1:0] d1_dst, d2_dst;
  logic                   kill_now;

  assign kill_now = |kill_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1_vld <= '0;
      d2_vld <= '0;
    end else begin
      d1_vld <= slot_vld;
      d2_vld <= kill_now ? '0 : d1_vld;
    end
    d1_idx <= slot_idx;
    d1_dst <= slot_dst;
    d2_idx <= d1_idx;
    d2_dst <= d1_dst;
  end

  always_comb begin
    kill_ent = '0;
    free_ent = '0;
    for (int k = 0; k < W; k++) begin
      ktag_vld[k]     = d2_vld[k] && kill_mask[k];
      ktag[k]         = d2_dst[k];
      ktag_vld[W + k] = kill_now && d1_vld[k];
      ktag[W + k]     = d1_dst[k];
      if (ktag_vld[k])      kill_ent[d2_idx[k]] = 1'b1;
      if (ktag_vld[W + k])  kill_ent[d1_idx[k]] = 1'b1;
      if (d2_vld[k] && !kill_mask[k]) free_ent[d2_idx[k]] = 1'b1;
    end
  end
endmodule

// File: rtl/iq_window.sv
module iq_window #(
  parameter int unsigned ENTRIES = iq_pkg::IQ_ENTRIES,
  parameter int unsigned WIDTH   = iq_pkg::IQ_WIDTH,
  parameter int unsigned TAG_W   = iq_pkg::IQ_TAG_W,
  parameter int unsigned OP_W    = iq_pkg::IQ_OP_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  output logic                     disp_ready,
  input  logic [TAG_W-1:0]         disp_src1,
  input  logic                     disp_src1_rdy,
  input  logic [TAG_W-1:0]         disp_src2,
  input  logic                     disp_src2_rdy,
  input  logic [TAG_W-1:0]         disp_dst,
  input  logic [OP_W-1:0]          disp_op,
  output logic [WIDTH-1:0]         iss_valid,
  output logic [WIDTH*OP_W-1:0]    iss_op,
  output logic [WIDTH*TAG_W-1:0]   iss_src1,
  output logic [WIDTH*TAG_W-1:0]   iss_src2,
  output logic [WIDTH*TAG_W-1:0]   iss_dst,
  output logic [2*WIDTH-1:0]       iss_byp,
  input  logic [WIDTH-1:0]         kill_mask
);
  localparam int unsigned IDXW = $clog2(ENTRIES);
  localparam int unsigned NS   = iq_pkg::IQ_NSRC;

  logic [ENTRIES-1:0]             vld_q, iss_q;
  logic [ENTRIES-1:0][NS-1:0]     rdy_q, byp_q;
  logic [ENTRIES-1:0][NS-1:0][TAG_W-1:0] src_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  dst_q;
  logic [ENTRIES-1:0][OP_W-1:0]   op_q;

  logic [ENTRIES-1:0]             req, grant, kill_ent, free_ent;
  logic [WIDTH-1:0]               slot_vld;
  logic [WIDTH-1:0][IDXW-1:0]     slot_idx;
  logic [WIDTH-1:0][TAG_W-1:0]    slot_dst;
  logic [2*WIDTH-1:0]             ktag_vld;
  logic [2*WIDTH-1:0][TAG_W-1:0]  ktag;
  logic [ENTRIES-1:0][NS-1:0]     wake, unwake;
  logic [NS-1:0][TAG_W-1:0]       in_src;
  logic [NS-1:0]                  in_rdy, in_wake;
  logic [IDXW-1:0]                alloc_idx;
  logic                           alloc_en, kill_now;

  assign kill_now = |kill_mask;
  assign req      = vld_q & ~iss_q & {ENTRIES{~kill_now}} &
                    {ENTRIES{1'b1}} & rdy_and(rdy_q);
  assign in_src   = {disp_src2, disp_src1};
  assign in_rdy   = {disp_src2_rdy, disp_src1_rdy};

  function automatic logic [ENTRIES-1:0] rdy_and(input logic [ENTRIES-1:0][NS-1:0] r);
    for (int e = 0; e < ENTRIES; e++) rdy_and[e] = &r[e];
  endfunction

  // lowest-numbered free entry
  always_comb begin
    alloc_idx  = '0;
    disp_ready = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (!vld_q[e]) begin
        alloc_idx  = IDXW'(e);
        disp_ready = 1'b1;
      end
  end
  assign alloc_en = disp_valid && disp_ready;

  iq_age_select #(.N(ENTRIES), .W(WIDTH), .IDXW(IDXW)) u_sel (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .req(req), .grant(grant), .slot_vld(slot_vld), .slot_idx(slot_idx)
  );

  iq_repair_track #(.N(ENTRIES), .W(WIDTH), .IDXW(IDXW), .TAGW(TAG_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_idx(slot_idx),
    .slot_dst(slot_dst), .kill_mask(kill_mask), .kill_ent(kill_ent),
    .free_ent(free_ent), .ktag_vld(ktag_vld), .ktag(ktag)
  );

  // wakeup broadcast and kill-driven readiness withdrawal
  always_comb begin
    for (int k = 0; k < WIDTH; k++) slot_dst[k] = dst_q[slot_idx[k]];
    for (int s = 0; s < NS; s++) begin
      in_wake[s] = 1'b0;
      for (int k = 0; k < WIDTH; k++)
        if (slot_vld[k] && in_src[s] == slot_dst[k]) in_wake[s] = 1'b1;
    end
    for (int e = 0; e < ENTRIES; e++)
      for (int s = 0; s < NS; s++) begin
        wake[e][s]   = 1'b0;
        unwake[e][s] = 1'b0;
        for (int k = 0; k < WIDTH; k++)
          if (slot_vld[k] && src_q[e][s] == slot_dst[k]) wake[e][s] = 1'b1;
        for (int j = 0; j < 2*WIDTH; j++)
          if (ktag_vld[j] && src_q[e][s] == ktag[j]) unwake[e][s] = 1'b1;
      end
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[e] <= 1'b0;
          iss_q[e] <= 1'b0;
          rdy_q[e] <= '0;
          byp_q[e] <= '0;
        end else if (alloc_en && alloc_idx == IDXW'(e)) begin
          vld_q[e] <= 1'b1;
          iss_q[e] <= 1'b0;
          rdy_q[e] <= in_rdy | in_wake;
          byp_q[e] <= in_wake;
        end else begin
          if (free_ent[e]) vld_q[e] <= 1'b0;
          if (grant[e]) iss_q[e] <= 1'b1;
          else if (kill_ent[e]) iss_q[e] <= 1'b0;
          rdy_q[e] <= (rdy_q[e] | wake[e]) & ~unwake[e];
          byp_q[e] <= wake[e];
        end
      end
      always_ff @(posedge clk) begin
        if (alloc_en && alloc_idx == IDXW'(e)) begin
          src_q[e] <= in_src;
          dst_q[e] <= disp_dst;
          op_q[e]  <= disp_op;
        end
      end
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      iss_valid[k]                  = slot_vld[k];
      iss_op[k*OP_W +: OP_W]        = slot_vld[k] ? op_q[slot_idx[k]] : '0;
      iss_src1[k*TAG_W +: TAG_W]    = slot_vld[k] ? src_q[slot_idx[k]][0] : '0;
      iss_src2[k*TAG_W +: TAG_W]    = slot_vld[k] ? src_q[slot_idx[k]][1] : '0;
      iss_dst[k*TAG_W +: TAG_W]     = slot_vld[k] ? slot_dst[k] : '0;
      iss_byp[2*k +: 2]             = slot_vld[k] ? byp_q[slot_idx[k]] : 2'b00;
    end
  end
endmodule

// File: rtl/iq_window_chk.sv
module iq_window_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [WIDTH-1:0] iss_valid,
  input logic [2*WIDTH-1:0] iss_byp,
  input logic [WIDTH-1:0] kill_mask
);
  // R2: slots fill from slot 0 upward without gaps
  generate
    for (genvar k = 0; k + 1 < WIDTH; k++) begin : g_fill
      p_fill_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[k+1] |-> iss_valid[k]);
    end
  endgenerate

  // R8: nothing issues in a kill cycle
  p_kill_blocks_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill_mask) |-> (iss_valid == '0));

  // R4: a forwarding flag needs an issue in the cycle before
  p_bypass_prior_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|iss_byp) |-> $past(|iss_valid));

  // R2: with no issue, no dispatch and no kill last cycle, nothing becomes eligible
  p_idle_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iss_valid) == '0 && !$past(disp_valid && disp_ready) && $past(kill_mask) == '0)
      |-> (iss_valid == '0));
endmodule

bind iq_window iq_window_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .iss_valid(iss_valid), .iss_byp(iss_byp), .kill_mask(kill_mask)
);

// File: tb/tb_iq_window.sv
module tb_iq_window;
  localparam int W = 4;
  localparam int T = 6;
  localparam int O = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_src1_rdy = 1'b0, disp_src2_rdy = 1'b0;
  logic [T-1:0] disp_src1 = '0, disp_src2 = '0, disp_dst = '0;
  logic [O-1:0] disp_op = '0;
  logic [W-1:0] kill_mask = '0;
  logic disp_ready;
  logic [W-1:0] iss_valid;
  logic [W*O-1:0] iss_op;
  logic [W*T-1:0] iss_src1, iss_src2, iss_dst;
  logic [2*W-1:0] iss_byp;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  iq_window dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
    .disp_src2(disp_src2), .disp_src2_rdy(disp_src2_rdy),
    .disp_dst(disp_dst), .disp_op(disp_op), .iss_valid(iss_valid),
    .iss_op(iss_op), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_dst(iss_dst), .iss_byp(iss_byp), .kill_mask(kill_mask)
  );

  typedef struct packed {
    logic         dv;
    logic [T-1:0] s1; logic r1;
    logic [T-1:0] s2; logic r2;
    logic [T-1:0] dst;
    logic [O-1:0] op;
    logic [W-1:0] kill;
    logic [W-1:0] ev;
    logic [O-1:0] eop0;
    logic [O-1:0] eop3;
    logic [1:0]   eb0;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    // serial chain A -> B -> C (R3, R4)
    '{1'b1, 6'd1, 1'b1, 6'd2, 1'b1, 6'd10, 8'd1, 4'h0, 4'h0, 8'd0, 8'd0, 2'b00},
    '{1'b1, 6'd10,1'b0, 6'd3, 1'b1, 6'd11, 8'd2, 4'h0, 4'h1, 8'd1, 8'd0, 2'b00},
    '{1'b1, 6'd11,1'b0, 6'd4, 1'b1, 6'd12, 8'd3, 4'h0, 4'h1, 8'd2, 8'd0, 2'b01},
    '{1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0,  8'd0, 4'h0, 4'h1, 8'd3, 8'd0, 2'b01},
    // five waiters on tag 20, then producer (R2, R5)
    '{1'b1, 6'd20,1'b0, 6'd5, 1'b1, 6'd21, 8'd4, 4'h0, 4'h0, 8'd0, 8'd0, 2'b00},
    '{1'b1, 6'd20,1'b0, 6'd5, 1'b1, 6'd22, 8'd5, 4'h0, 4'h0, 8'd0, 8'd0, 2'b00},
    '{1'b1, 6'd20,1'b0, 6'd5, 1'b1, 6'd23, 8'd6, 4'h0, 4'h0, 8'd0, 8'd0, 2'b00},
    '{1'b1, 6'd20,1'b0, 6'd5, 1'b1, 6'd24, 8'd7, 4'h0, 4'h0, 8'd0, 8'd0, 2'b00},
    '{1'b1, 6'd20,1'b0, 6'd5, 1'b1, 6'd25, 8'd8, 4'h0, 4'h0, 8'd0, 8'd0, 2'b00},
    '{1'b1, 6'd6, 1'b1, 6'd7, 1'b1, 6'd20, 8'd9, 4'h0, 4'h0, 8'd0, 8'd0, 2'b00},
    '{1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0,  8'd0, 4'h0, 4'h1, 8'd9, 8'd0, 2'b00},
    '{1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0,  8'd0, 4'h0, 4'hF, 8'd4, 8'd7, 2'b01},
    '{1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0,  8'd0, 4'h0, 4'h1, 8'd8, 8'd0, 2'b00},
    // chain Q -> R -> S with a kill of Q (R6, R7, R8)
    '{1'b1, 6'd1, 1'b1, 6'd2, 1'b1, 6'd30, 8'd10,4'h0, 4'h0, 8'd0, 8'd0, 2'b00},
    '{1'b1, 6'd30,1'b0, 6'd3, 1'b1, 6'd31, 8'd11,4'h0, 4'h1, 8'd10,8'd0, 2'b00},
    '{1'b1, 6'd31,1'b0, 6'd4, 1'b1, 6'd32, 8'd12,4'h0, 4'h1, 8'd11,8'd0, 2'b01},
    '{1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0,  8'd0, 4'h1, 4'h0, 8'd0, 8'd0, 2'b00},
    '{1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0,  8'd0, 4'h0, 4'h1, 8'd10,8'd0, 2'b00},
    '{1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0,  8'd0, 4'h0, 4'h1, 8'd11,8'd0, 2'b01},
    '{1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0,  8'd0, 4'h0, 4'h1, 8'd12,8'd0, 2'b01},
    '{1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 6'd0,  8'd0, 4'h0, 4'h0, 8'd0, 8'd0, 2'b00}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic dv, input logic [T-1:0] s1, input logic r1,
                       input logic [T-1:0] s2, input logic r2,
                       input logic [T-1:0] dst, input logic [O-1:0] op,
                       input logic [W-1:0] km);
    disp_valid = dv; disp_src1 = s1; disp_src1_rdy = r1;
    disp_src2 = s2; disp_src2_rdy = r2; disp_dst = dst; disp_op = op;
    kill_mask = km;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int issued;
    bit saw_bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: empty after reset
    chk(disp_ready === 1'b1, "R10 ready", 64'(disp_ready), 64'd1);
    chk(iss_valid === '0, "R10 valid", 64'(iss_valid), 64'd0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].dv, VEC[i].s1, VEC[i].r1, VEC[i].s2, VEC[i].r2,
            VEC[i].dst, VEC[i].op, VEC[i].kill);
      #1;
      chk(iss_valid === VEC[i].ev, $sformatf("R2/R3/R6/R7/R8 row%0d valid", i),
          64'(iss_valid), 64'(VEC[i].ev));
      if (VEC[i].ev[0]) begin
        chk(iss_op[O-1:0] === VEC[i].eop0, $sformatf("R2 row%0d op slot0", i),
            64'(iss_op[O-1:0]), 64'(VEC[i].eop0));
        chk(iss_byp[1:0] === VEC[i].eb0, $sformatf("R4/R5 row%0d byp slot0", i),
            64'(iss_byp[1:0]), 64'(VEC[i].eb0));
      end
      if (VEC[i].ev[3])
        chk(iss_op[3*O +: O] === VEC[i].eop3, $sformatf("R2 row%0d op slot3", i),
            64'(iss_op[3*O +: O]), 64'(VEC[i].eop3));
      @(negedge clk);
    end
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0, '0, '0);
    repeat (4) @(negedge clk);

    // capacity: 15 waiters on tag 40, then the producer as 16th entry
    for (int i = 0; i < 15; i++) begin
      drive(1'b1, 6'd40, 1'b0, 6'd5, 1'b1, 6'(41 + i), 8'(20 + i), '0);
      @(negedge clk);
    end
    drive(1'b1, 6'd1, 1'b1, 6'd2, 1'b1, 6'd40, 8'd50, '0);
    @(negedge clk);
    // offer a dispatch that must be dropped while full
    drive(1'b1, 6'd1, 1'b1, 6'd2, 1'b1, 6'd60, 8'd99, '0);
    #1;
    chk(disp_ready === 1'b0, "R1 full", 64'(disp_ready), 64'd0);
    issued = 0;
    saw_bad = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      if (c == 4) begin
        drive(1'b0, '0, 1'b0, '0, 1'b0, '0, '0, '0);
        #1;
        chk(disp_ready === 1'b1, "R9 freed two cycles after issue",
            64'(disp_ready), 64'd1);
      end
      if (c == 3)
        chk(disp_ready === 1'b0, "R9 not freed early", 64'(disp_ready), 64'd0);
      if (c == 2)
        chk(iss_valid === 4'hF && iss_byp === 8'h55, "R3/R4 wide wake",
            64'({iss_valid, iss_byp}), 64'({4'hF, 8'h55}));
      for (int k = 0; k < W; k++)
        if (iss_valid[k]) begin
          issued++;
          if (iss_op[k*O +: O] == 8'd99) saw_bad = 1'b1;
        end
      @(negedge clk);
      #1;
    end
    chk(issued == 16, "R1 issued count", 64'(issued), 64'd16);
    chk(!saw_bad, "R1 dropped dispatch never issues", 64'(saw_bad), 64'd0);
    report();
  end
endmodule